// File: doc/BRIEF.md
# Round-robin VOQ matching scheduler

This block decides, once per cell slot, which inputs of an input-queued crossbar may send a cell to which outputs. Each input keeps one queue per output, and the scheduler sees one flag per queue saying whether that queue holds a cell. From these flags it builds a matching: every input is paired with at most one output and every output with at most one input. The matching drives the crossbar for the coming slot.

The matching is found by repeated rounds of request, grant and accept. In each round, every output still free picks one of the free inputs that want it. It starts from its own round-robin pointer. Every input that received grants then picks one of them, starting from its own pointer. Pairs formed in a round are removed before the next round. The pointers move only for pairs formed in the first round, and each moves to one place past the partner it was just paired with. A port that was just served therefore has the lowest priority next time, and under heavy load the arbiters settle into distinct pointers that rotate in step.

The number of rounds is a parameter. All rounds are evaluated within the cycle in which a slot is started, and the result is held in registers from the next cycle on.

Top module: `voq_rr_matcher`

## Requirements
- R1: While `rst` is high at a clock edge, every grant and accept pointer is set to 0 and `match_valid` and `match_port` are cleared to 0.
- R2: No two inputs with `match_valid` set ever carry the same output number in `match_port`.
- R3: Input i is matched to output j only if request bit `voq_req[i*N_PORTS+j]` was 1 when the slot started.
- R4: In every round, each free output grants the first free requesting input at or after its grant pointer, counting upward and wrapping. Each input accepts the first granting output at or after its accept pointer in the same way.
- R5: For a pair formed in the first round, the output's grant pointer becomes (accepting input + 1) mod N_PORTS and the input's accept pointer becomes (accepted output + 1) mod N_PORTS.
- R6: A grant pointer whose grant was not accepted in the first round, an accept pointer of an input not matched in the first round, and every pointer touched only by later rounds all keep their value.
- R7: A later round considers only inputs and outputs left unmatched by earlier rounds. With ITERS = N_PORTS, the final matching leaves no free input that requests a free output.
- R8: Results of a slot started by `slot_start` at a clock edge appear on the outputs after that edge. While `slot_start` is low, the outputs and the pointers hold their values, whatever `voq_req` does.
- R9: With ITERS = 1, only the pairs of the first round are reported.
- R10: `match_port[i*W +: W]` (W = log2 N_PORTS) holds the output number for input i when `match_valid[i]` is 1, and is 0 when `match_valid[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | Evaluate a matching from `voq_req` at this edge |
| voq_req | input | N_PORTS*N_PORTS | Queue non-empty flags, bit i*N_PORTS+j for input i to output j |
| match_valid | output | N_PORTS | Input i has been given an output |
| match_port | output | N_PORTS*W | Output number per input, field i at bits i*W+W-1 down to i*W |

## Verification
The hardest state to reach is one where the grant pointers have been pulled apart. Only then do the rules on pointer movement, wrap-around and unaccepted grants show up at the ports, and from reset every pointer is 0. The stimulus therefore runs a fixed chain of slots from reset, and each expected matching follows from the pointer values the earlier slots left behind. A few slots request everything, which spreads the pointers apart and exercises later rounds. Then slots with a single contended output walk that output's grant pointer around the ring. Finally, one input requesting two outputs shows an unaccepted grant leaving its pointer unchanged. A second instance with a single round is driven with the same slots, so that its result can be compared with the iterated result.

// File: rtl/voq_rr_pkg.sv
package voq_rr_pkg;

  // Pointer advance: one place past idx, wrapping at n.
  function automatic int unsigned rr_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/voq_rr_ppe.sv
// Programmable priority encoder: first set bit at or after ptr, wrapping.
module voq_rr_ppe #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         hit,
  output logic [W-1:0] sel
);

  logic [W:0]   pos;
  logic [W-1:0] idx;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    pos = '0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, ptr} + (W+1)'(k);
      if (pos >= (W+1)'(N)) pos = pos - (W+1)'(N);
      idx = pos[W-1:0];
      if (!hit && req[idx]) begin
        hit = 1'b1;
        sel = idx;
      end
    end
  end

  // R4: a decision always names a requesting port, and one is made whenever any port requests
  always_comb begin
    if (hit) p_sel_requests_r4: assert (req[sel]);
    p_hit_any_r4: assert (hit == (|req));
  end

endmodule

// File: rtl/voq_rr_round.sv
// One request-grant-accept round over the ports still free.
module voq_rr_round #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0][N-1:0] req,       // req[i][j]: input i has a cell for output j
  input  logic [N-1:0]        in_free,
  input  logic [N-1:0]        out_free,
  input  logic [N-1:0][W-1:0] gptr,
  input  logic [N-1:0][W-1:0] aptr,
  output logic [N-1:0]        acc_valid, // per input
  output logic [N-1:0][W-1:0] acc_sel,   // per input: accepted output
  output logic [N-1:0]        out_taken, // per output: its grant was accepted
  output logic [N-1:0][W-1:0] gnt_sel,   // per output: granted input
  output logic [N-1:0]        in_free_nx,
  output logic [N-1:0]        out_free_nx
);

  logic [N-1:0][N-1:0] col_req;  // col_req[j][i]
  logic [N-1:0][N-1:0] row_gnt;  // row_gnt[i][j]
  logic [N-1:0]        gnt_hit;

  for (genvar j = 0; j < N; j++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_col
      assign col_req[j][i] = req[i][j] & in_free[i] & out_free[j];
    end
    voq_rr_ppe #(.N(N)) u_grant (
      .req (col_req[j]),
      .ptr (gptr[j]),
      .hit (gnt_hit[j]),
      .sel (gnt_sel[j])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    for (genvar j = 0; j < N; j++) begin : g_row
      assign row_gnt[i][j] = gnt_hit[j] && (gnt_sel[j] == W'(i));
    end
    voq_rr_ppe #(.N(N)) u_accept (
      .req (row_gnt[i]),
      .ptr (aptr[i]),
      .hit (acc_valid[i]),
      .sel (acc_sel[i])
    );
  end

  for (genvar j = 0; j < N; j++) begin : g_taken
    assign out_taken[j] = gnt_hit[j] && acc_valid[gnt_sel[j]] && (acc_sel[gnt_sel[j]] == W'(j));
  end

  assign in_free_nx  = in_free  & ~acc_valid;
  assign out_free_nx = out_free & ~out_taken;

  // R3/R7: an acceptance joins a free input to a free output it requested
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (acc_valid[i]) begin
        p_acc_legal_r3: assert (req[i][acc_sel[i]] && in_free[i] && out_free[acc_sel[i]]);
      end
    end
    p_pairs_balance_r2: assert ($countones(acc_valid) == $countones(out_taken));
  end

endmodule

// File: rtl/voq_rr_matcher.sv
module voq_rr_matcher #(
  parameter int N_PORTS = 4,
  parameter int ITERS   = N_PORTS,
  localparam int W      = $clog2(N_PORTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   slot_start,
  input  logic [N_PORTS*N_PORTS-1:0] voq_req,
  output logic [N_PORTS-1:0]     match_valid,
  output logic [N_PORTS*W-1:0]   match_port
);
  import voq_rr_pkg::*;

  localparam int N = N_PORTS;

  logic [N-1:0][N-1:0] req2d;
  logic [N-1:0][W-1:0] gptr_q, aptr_q;

  logic [ITERS:0][N-1:0]         free_in, free_out;
  logic [ITERS-1:0][N-1:0]       r_acc_v, r_taken;
  logic [ITERS-1:0][N-1:0][W-1:0] r_acc_s, r_gnt_s;

  logic [N-1:0]        fin_valid;
  logic [N-1:0][W-1:0] fin_sel;

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign req2d[i] = voq_req[i*N +: N];
  end

  assign free_in[0]  = '1;
  assign free_out[0] = '1;

  for (genvar t = 0; t < ITERS; t++) begin : g_round
    voq_rr_round #(.N(N)) u_round (
      .req        (req2d),
      .in_free    (free_in[t]),
      .out_free   (free_out[t]),
      .gptr       (gptr_q),
      .aptr       (aptr_q),
      .acc_valid  (r_acc_v[t]),
      .acc_sel    (r_acc_s[t]),
      .out_taken  (r_taken[t]),
      .gnt_sel    (r_gnt_s[t]),
      .in_free_nx (free_in[t+1]),
      .out_free_nx(free_out[t+1])
    );
  end

  // Merge the rounds: each input is accepted in at most one round.
  always_comb begin
    fin_valid = '0;
    fin_sel   = '0;
    for (int t = 0; t < ITERS; t++) begin
      for (int i = 0; i < N; i++) begin
        if (r_acc_v[t][i]) begin
          fin_valid[i] = 1'b1;
          fin_sel[i]   = r_acc_s[t][i];
        end
      end
    end
  end

  // Pointers move only on pairs formed in the first round.
  always_ff @(posedge clk) begin
    if (rst) begin
      gptr_q <= '0;
      aptr_q <= '0;
    end else if (slot_start) begin
      for (int j = 0; j < N; j++) begin
        if (r_taken[0][j]) gptr_q[j] <= W'(rr_next(int'(r_gnt_s[0][j]), N));
      end
      for (int i = 0; i < N; i++) begin
        if (r_acc_v[0][i]) aptr_q[i] <= W'(rr_next(int'(r_acc_s[0][i]), N));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid <= '0;
      match_port  <= '0;
    end else if (slot_start) begin
      match_valid <= fin_valid;
      match_port  <= fin_sel;
    end
  end

  // ---------------- assertions ----------------
  for (genvar a = 0; a < N; a++) begin : g_chk_pair
    for (genvar b = a + 1; b < N; b++) begin : g_chk_b
      p_unique_out_r2: assert property (@(posedge clk) disable iff (rst)
        !(match_valid[a] && match_valid[b] && match_port[a*W +: W] == match_port[b*W +: W]));
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk_in
    p_first_round_kept_r5: assert property (@(posedge clk) disable iff (rst)
      slot_start && r_acc_v[0][i] |=> match_valid[i]);
    p_aptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !(slot_start && r_acc_v[0][i]) |=> $stable(aptr_q[i]));
    p_idle_field_r10: assert property (@(posedge clk) disable iff (rst)
      !match_valid[i] |-> match_port[i*W +: W] == '0);
  end

  for (genvar j = 0; j < N; j++) begin : g_chk_out
    p_gptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !(slot_start && r_taken[0][j]) |=> $stable(gptr_q[j]));
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !slot_start |=> $stable(match_valid) && $stable(match_port));

  if (ITERS == N) begin : g_chk_maximal
    // R7: after N rounds no free input still requests a free output
    always_comb begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          p_maximal_r7: assert (!(req2d[i][j] && free_in[ITERS][i] && free_out[ITERS][j]));
        end
      end
    end
  end

endmodule

// File: tb/tb_voq_rr_matcher.sv
`timescale 1ns/1ps
module tb_voq_rr_matcher;

  localparam int N = 4;
  localparam int W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             slot_start = 1'b0;
  logic [N*N-1:0]   voq_req = '0;
  logic [N-1:0]     mv, mv1;
  logic [N*W-1:0]   mp, mp1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  voq_rr_matcher #(.N_PORTS(N), .ITERS(N)) dut (
    .clk(clk), .rst(rst), .slot_start(slot_start), .voq_req(voq_req),
    .match_valid(mv), .match_port(mp));

  voq_rr_matcher #(.N_PORTS(N), .ITERS(1)) dut1 (
    .clk(clk), .rst(rst), .slot_start(slot_start), .voq_req(voq_req),
    .match_valid(mv1), .match_port(mp1));

  // {request flags (bit 4*i+j), expected valid, expected fields (2 bits per input)}
  // Chain from reset; each entry depends on the pointers the previous ones left.
  localparam logic [27:0] VEC [10] = '{
    {16'hFFFF, 4'hF, 8'hE4},  // all request: rounds 2-4 fill the diagonal (R7)
    {16'hFFFF, 4'hF, 8'hE1},  // pointers moved by first round only (R5, R6)
    {16'hFFFF, 4'hF, 8'hC6},
    {16'hFFFF, 4'hF, 8'h1B},  // pointers desynchronised: full match in round 1
    {16'h0000, 4'h0, 8'h00},  // no requests (R10 zero fields)
    {16'h4444, 4'h4, 8'h20},  // output 2 contended, its pointer walks (R4)
    {16'h4444, 4'h8, 8'h80},
    {16'h4444, 4'h1, 8'h02},  // wrap to input 0
    {16'h0090, 4'h2, 8'h0C},  // input 1 wants 0 and 3, accepts 3 (R4)
    {16'h0090, 4'h2, 8'h00}   // unaccepted grant of out 0 kept its pointer (R6)
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_slot(input logic [N*N-1:0] r);
    @(negedge clk);
    voq_req    = r;
    slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid after reset", 32'(mv), 32'h0);
    chk("R1 fields after reset", 32'(mp), 32'h0);

    // R8: requests without a slot start change nothing
    voq_req = '1;
    repeat (2) @(negedge clk);
    chk("R8 no start valid", 32'(mv), 32'h0);

    for (int k = 0; k < 10; k++) begin
      run_slot(VEC[k][27:12]);
      chk($sformatf("R2 R3 R4 R5 vec %0d valid", k), 32'(mv), 32'(VEC[k][11:8]));
      chk($sformatf("R4 R10 vec %0d fields", k), 32'(mp), 32'(VEC[k][7:0]));
      if (k == 0) begin
        chk("R9 single round valid", 32'(mv1), 32'h1);
        chk("R9 single round fields", 32'(mp1), 32'h00);
      end
      if (k == 1) begin
        chk("R9 single round valid slot 2", 32'(mv1), 32'h3);
        chk("R9 single round fields slot 2", 32'(mp1), 32'h01);
      end
    end

    // R8: hold while slot_start low, outputs and pointers
    voq_req = '1;
    repeat (3) @(negedge clk);
    chk("R8 hold valid", 32'(mv), 32'h2);
    chk("R8 hold fields", 32'(mp), 32'h00);
    run_slot('1);
    chk("R6 R8 pointers held valid", 32'(mv), 32'hF);
    chk("R6 R8 pointers held fields", 32'(mp), 32'h78);

    // R1: reset restores pointers
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 valid cleared", 32'(mv), 32'h0);
    chk("R1 fields cleared", 32'(mp), 32'h0);
    run_slot('1);
    chk("R1 R7 pointers reset fields", 32'(mp), 32'hE4);
    chk("R9 single round after reset", 32'(mv1), 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule